// File: doc/BRIEF.md
# Repetition-Gated PWM Timer with Combined Duty/Count Word

This is a single-output PWM timer. A free-running counter steps from zero up to a programmed period value and then wraps. The output goes high at the start of every period and drops when the counter reaches the compare value, so the compare value sets the duty cycle. A repetition counter groups periods into blocks. The timer keeps the current compare value and period for a whole block.

The repetition value and the compare value can both be written in one 32-bit word. The upper half is the repetition count and the lower half is the compare value. A written word, and a new period, wait in shadow registers until the current block ends. At that point they become active, and the timer pulses a request strobe. An external transfer master answers the strobe by writing the next word.

If the master feeds a run word (non-zero compare, short count) and an idle word (zero compare, longer count) in alternation, the output bursts: a few active periods, then several silent ones.

Top module: `pwm_rep_burst`

## Requirements
- R1: While rst_ni is low and after reset with en_i low, pwm_o and dma_req_o are 0.
- R2: While running, each PWM period lasts PER+1 clocks, where PER is the active period value (the counter runs 0..PER).
- R3: In each period pwm_o is high for the first min(CMP, PER+1) clocks and low for the rest. With CMP above PER the output stays high throughout. With CMP equal to 0 it never goes high.
- R4: The combined word carries the repetition count in bits [31:16] and the compare value in bits [15:0]. A single write sets both.
- R5: A repetition value N holds the same compare value and period for N+1 consecutive periods, which form one block.
- R6: dma_req_o is a one-clock pulse. It is high in the first clock of each new block (counter at zero), so successive pulses are (N+1)*(PER+1) clocks apart.
- R7: Combined-word and period writes made while running do not alter the current block. They take effect at the start of the next block.
- R8: While en_i is low, the counter is held, pwm_o is low and writes go straight to the active values. pwm_o rises two clocks after en_i is first sampled high (for CMP > 0), and it is low by the second clock after en_i is sampled low.
- R9: With PER = 4095, alternating the words 0x00030000 and 0x00010800 gives 2 active periods of 2048 high clocks in every 6 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the counter and forces the output low |
| per_we_i | input | 1 | Period write strobe |
| per_wdata_i | input | CNT_W | Period value (period length is value+1 clocks) |
| cw_we_i | input | 1 | Combined word write strobe |
| cw_wdata_i | input | REP_W+CNT_W | Combined word: {repetition, compare} |
| pwm_o | output | 1 | PWM output, registered |
| dma_req_o | output | 1 | One-clock request for the next combined word |

## Verification
pwm_o is registered one clock behind the counter. A request pulse therefore marks the clock in which the new block's counter is at zero, and the new block's first output clock comes one cycle after the pulse. After the request, the bench counts high clocks over whole windows of PER+1 clocks, and it records the index of the next request inside the same window. Period length, duty and block length are thus checked from one aligned stream, without guessing where a period begins. The enable and disable checks are sampled at the first and second falling edges after the edge that captures en_i, which matches the two-register path from enable to output.

// File: rtl/pwm_rep_burst_pkg.sv
package pwm_rep_burst_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_REP_W = 16;
endpackage

// File: rtl/pwm_rep_burst_shadow.sv
module pwm_rep_burst_shadow #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         xfer_i,
  output logic [W-1:0] act_o
);
  logic [W-1:0] pre_q;
  logic [W-1:0] act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (we_i) begin
      pre_q <= wdata_i;
    end
  end

  // transfer uses the shadow value held before this edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (xfer_i) begin
      act_q <= pre_q;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/pwm_rep_burst_regs.sv
module pwm_rep_burst_regs #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   rep_evt_i,
  input  logic                   per_we_i,
  input  logic [CNT_W-1:0]       per_wdata_i,
  input  logic                   cw_we_i,
  input  logic [REP_W+CNT_W-1:0] cw_wdata_i,
  output logic [CNT_W-1:0]       per_act_o,
  output logic [CNT_W-1:0]       cmp_act_o,
  output logic [REP_W-1:0]       rep_act_o
);
  localparam int unsigned CW_W = REP_W + CNT_W;

  logic             xfer;
  logic [REP_W-1:0] cw_rep;
  logic [CNT_W-1:0] cw_cmp;

  assign xfer   = !run_i || rep_evt_i;
  assign cw_rep = cw_wdata_i[CW_W-1:CNT_W];
  assign cw_cmp = cw_wdata_i[CNT_W-1:0];

  pwm_rep_burst_shadow #(.W(CNT_W)) u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (per_we_i),
    .wdata_i (per_wdata_i),
    .xfer_i  (xfer),
    .act_o   (per_act_o)
  );

  pwm_rep_burst_shadow #(.W(CNT_W)) u_cmp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cw_we_i),
    .wdata_i (cw_cmp),
    .xfer_i  (xfer),
    .act_o   (cmp_act_o)
  );

  pwm_rep_burst_shadow #(.W(REP_W)) u_rep (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cw_we_i),
    .wdata_i (cw_rep),
    .xfer_i  (xfer),
    .act_o   (rep_act_o)
  );

  // R7
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmp_act_o) |-> $past(!run_i || rep_evt_i));

  // R7
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_act_o) |-> $past(!run_i || rep_evt_i));
endmodule

// File: rtl/pwm_rep_burst_counter.sv
module pwm_rep_burst_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_act_i,
  input  logic [REP_W-1:0] rep_act_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rep_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [REP_W-1:0] blk_q;
  logic             per_evt;

  assign per_evt   = run_i && (cnt_q == per_act_i);
  assign rep_evt_o = per_evt && (blk_q == rep_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i || per_evt) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // periods elapsed in the current block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q <= '0;
    end else if (!run_i || rep_evt_o) begin
      blk_q <= '0;
    end else if (per_evt) begin
      blk_q <= blk_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q <= per_act_i));

  // R5
  blk_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (blk_q <= rep_act_i));
endmodule

// File: rtl/pwm_rep_burst_out.sv
module pwm_rep_burst_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_act_i,
  output logic             pwm_o
);
  logic pwm_q;

  // high from period start until the counter meets compare
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else begin
      pwm_q <= run_i && (cnt_i < cmp_act_i);
    end
  end

  assign pwm_o = pwm_q;

  // R3
  zero_cmp_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_act_i == '0) && $past(cmp_act_i == '0)) |-> !pwm_q);
endmodule

// File: rtl/pwm_rep_burst.sv
module pwm_rep_burst #(
  parameter int unsigned CNT_W = pwm_rep_burst_pkg::DEF_CNT_W,
  parameter int unsigned REP_W = pwm_rep_burst_pkg::DEF_REP_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   per_we_i,
  input  logic [CNT_W-1:0]       per_wdata_i,
  input  logic                   cw_we_i,
  input  logic [REP_W+CNT_W-1:0] cw_wdata_i,
  output logic                   pwm_o,
  output logic                   dma_req_o
);
  logic             run_q;
  logic             req_q;
  logic             rep_evt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_act;
  logic [CNT_W-1:0] cmp_act;
  logic [REP_W-1:0] rep_act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      run_q <= en_i;
      req_q <= rep_evt;
    end
  end

  pwm_rep_burst_regs #(.CNT_W(CNT_W), .REP_W(REP_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .rep_evt_i   (rep_evt),
    .per_we_i    (per_we_i),
    .per_wdata_i (per_wdata_i),
    .cw_we_i     (cw_we_i),
    .cw_wdata_i  (cw_wdata_i),
    .per_act_o   (per_act),
    .cmp_act_o   (cmp_act),
    .rep_act_o   (rep_act)
  );

  pwm_rep_burst_counter #(.CNT_W(CNT_W), .REP_W(REP_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .per_act_i (per_act),
    .rep_act_i (rep_act),
    .cnt_o     (cnt),
    .rep_evt_o (rep_evt)
  );

  pwm_rep_burst_out #(.CNT_W(CNT_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .cnt_i     (cnt),
    .cmp_act_i (cmp_act),
    .pwm_o     (pwm_o)
  );

  assign dma_req_o = req_q;

  // R6
  req_at_block_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> (cnt == '0));

  // R8
  idle_out_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && $past(!run_q)) |-> !pwm_o);
endmodule

// File: tb/tb_pwm_rep_burst.sv
`timescale 1ns/1ps
module tb_pwm_rep_burst;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        per_we_i = 1'b0;
  logic [15:0] per_wdata_i = '0;
  logic        cw_we_i = 1'b0;
  logic [31:0] cw_wdata_i = '0;
  logic        pwm_o;
  logic        dma_req_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pwm_rep_burst dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .per_we_i    (per_we_i),
    .per_wdata_i (per_wdata_i),
    .cw_we_i     (cw_we_i),
    .cw_wdata_i  (cw_wdata_i),
    .pwm_o       (pwm_o),
    .dma_req_o   (dma_req_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr_cw(input logic [31:0] w);
    @(negedge clk_i);
    cw_we_i = 1'b1; cw_wdata_i = w;
    @(negedge clk_i);
    cw_we_i = 1'b0;
  endtask

  task automatic wr_per(input logic [15:0] p);
    @(negedge clk_i);
    per_we_i = 1'b1; per_wdata_i = p;
    @(negedge clk_i);
    per_we_i = 1'b0;
  endtask

  task automatic wait_req(input int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!dma_req_o && n < maxc);
    if (!dma_req_o) chk(1'b0, "R6", "request timeout", n, maxc);
  endtask

  // counts high clocks, requests and index of first request over n clocks
  task automatic run_window(input int n, output int highs, output int nreq,
                            output int first);
    highs = 0; nreq = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
      if (dma_req_o) begin
        nreq++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic setup(input logic [15:0] p, input logic [31:0] w);
    @(negedge clk_i);
    en_i = 1'b0;
    cyc(2);
    wr_per(p);
    wr_cw(w);
    cyc(2);
  endtask

  task automatic t_reset();
    chk(pwm_o == 1'b0, "R1", "pwm in reset", pwm_o, 0);
    chk(dma_req_o == 1'b0, "R1", "req in reset", dma_req_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    cyc(3);
    chk(pwm_o == 1'b0, "R1", "pwm idle after reset", pwm_o, 0);
    chk(dma_req_o == 1'b0, "R1", "req idle after reset", dma_req_o, 0);
  endtask

  task automatic t_enable();
    int n, h, r, f;
    setup(16'd4, 32'h0001_0002);
    chk(pwm_o == 1'b0, "R8", "pwm while disabled", pwm_o, 0);
    en_i = 1'b1;
    @(negedge clk_i);
    chk(pwm_o == 1'b0, "R8", "pwm one clock after enable", pwm_o, 0);
    @(negedge clk_i);
    chk(pwm_o == 1'b1, "R8", "pwm two clocks after enable", pwm_o, 1);
    wait_req(100, n);
    run_window(10, h, r, f);
    chk(f == 10, "R5", "block spacing rep=1 per=4", f, 10);
    chk(r == 1, "R6", "single-clock request pulses", r, 1);
    chk(h == 4, "R3", "highs over two periods cmp=2", h, 4);
  endtask

  task automatic t_duty();
    int n, h, r, f;
    setup(16'd9, 32'h0000_0003);
    en_i = 1'b1;
    wait_req(100, n);
    run_window(10, h, r, f);
    chk(h == 3, "R3", "duty cmp=3 per=9", h, 3);
    chk(f == 10, "R2", "period length per=9", f, 10);
    wr_cw(32'h0000_000C);
    wait_req(100, n);
    run_window(10, h, r, f);
    chk(h == 10, "R3", "cmp above period stays high", h, 10);
    wr_cw(32'h0000_0000);
    wait_req(100, n);
    run_window(20, h, r, f);
    chk(h == 0, "R3", "cmp zero stays low", h, 0);
  endtask

  task automatic t_shadow();
    int n, h, r, f;
    int hp[4];
    int first;
    setup(16'd9, 32'h0003_0002);
    en_i = 1'b1;
    wait_req(200, n);
    foreach (hp[k]) hp[k] = 0;
    first = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (pwm_o) hp[i / 10]++;
      if (dma_req_o && first == 0) first = i + 1;
      if (i == 12) begin
        per_we_i = 1'b1; per_wdata_i = 16'd7;
        cw_we_i = 1'b1; cw_wdata_i = 32'h0000_0003;
      end else if (i == 13) begin
        per_we_i = 1'b0; cw_we_i = 1'b0;
      end
    end
    for (int k = 0; k < 4; k++)
      chk(hp[k] == 2, "R7", "duty kept within block", hp[k], 2);
    chk(first == 40, "R7", "block length kept after write", first, 40);
    run_window(8, h, r, f);
    chk(h == 3, "R7", "new compare after block", h, 3);
    chk(f == 8, "R7", "new period after block", f, 8);
    wr_cw(32'h0002_0005);
    wait_req(100, n);
    run_window(24, h, r, f);
    chk(h == 15, "R4", "compare field from low half", h, 15);
    chk(f == 24, "R4", "repetition field from high half", f, 24);
  endtask

  task automatic t_disable();
    int h, r, f;
    @(negedge clk_i);
    en_i = 1'b0;
    cyc(2);
    chk(pwm_o == 1'b0, "R8", "pwm low after disable", pwm_o, 0);
    run_window(20, h, r, f);
    chk(h == 0, "R8", "no output while disabled", h, 0);
    chk(r == 0, "R8", "no request while disabled", r, 0);
  endtask

  task automatic t_burst();
    int n;
    int h_run = 0;
    int h_all = 0;
    int reqs = 0;
    logic [31:0] nxt;
    setup(16'd4095, 32'h0003_0000);
    en_i = 1'b1;
    wr_cw(32'h0001_0800);
    wait_req(30000, n);
    nxt = 32'h0003_0000;
    for (int i = 0; i < 6 * 4096; i++) begin
      @(negedge clk_i);
      cw_we_i = 1'b0;
      if (pwm_o) begin
        h_all++;
        if (i < 2 * 4096) h_run++;
      end
      if (i == 0 || dma_req_o) begin
        if (dma_req_o) reqs++;
        cw_we_i = 1'b1;
        cw_wdata_i = nxt;
        nxt = (nxt == 32'h0003_0000) ? 32'h0001_0800 : 32'h0003_0000;
      end
    end
    @(negedge clk_i);
    cw_we_i = 1'b0;
    chk(h_run == 4096, "R9", "two active periods", h_run, 4096);
    chk(h_all == 4096, "R9", "idle periods silent", h_all, 4096);
    chk(reqs == 2, "R9", "requests per six periods", reqs, 2);
  endtask

  initial begin
    cyc(150000);
    if (!done) begin
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(2);
    t_reset();
    t_enable();
    t_duty();
    t_shadow();
    t_disable();
    t_burst();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule